// File: doc/BRIEF.md
# Four-Timeslot TDM Serial Channel Port

This block connects a device to a continuous time-division serial bus at 2048 kb/s. Each 125 µs frame (8 kHz) holds 32 timeslots of eight bits. The port runs on the double-rate bus clock, so every bit cell spans two clock periods. The rising edge of `clk_i` stands for the bus edge on which the frame pulse is qualified. A low level on the frame pulse at such an edge aligns the bit and timeslot counters.

Only the first four timeslots are handled. Timeslot 0 is a signalling slot whose two least significant bits carry data. Timeslot 1 is a control octet. Timeslots 2 and 3 are plain octet slots. On transmit, each slot is gated by its own enable bit, and a per-cell output enable tells the pad when to drive the shared line. Outside its own cells the line is left tri-stated. On receive, each handled slot is captured into a parallel register whatever its enable says. A one-cycle strobe marks each new value.

Octets go over the wire most significant bit first. Incoming bits are sampled at the three-quarter point of their cell. Outgoing bits change only at the start of a cell.

Top module: `tdm_slot_port`

## Requirements
- R1: While `rst_ni` is low and until the first frame pulse, `doe_o`, `dout_o`, `rx_vld_o`, `rx_dch_o` and `rx_oct_o` are all zero.
- R2: When `fp_ni` is low at a rising clock edge, the next cycle is the first half of the first cell (bit 7) of timeslot 0. A pulse arriving in the middle of a frame realigns the counters in the same way.
- R3: Transmit bits go out most significant first (bit 7 in the first cell of a slot). Each bit is held for the two cycles of its cell, and `dout_o`/`doe_o` change only at a cell start.
- R4: In timeslot 0, bit positions 7..2 have `doe_o`=0. Positions 1 and 0 have `doe_o`=1 and carry `tx_dch_i[1]`/`tx_dch_i[0]` when `en_i[0]`=1, and are driven as 0 when `en_i[0]`=0.
- R5: In timeslot s (1..3), with `en_i[s]`=1 the port drives `tx_oct_i[(s-1)*8 +: 8]` with `doe_o`=1. With `en_i[s]`=0, `doe_o`=0 for the whole slot.
- R6: In timeslots 4..31, and at all times before the first frame pulse, `doe_o`=0 and `dout_o`=0.
- R7: `rx_i` is sampled on the falling clock edge inside the second cycle of each cell, which is the three-quarter point, and octets are assembled MSB first. Slot 0's two LSBs go to `rx_dch_o`, and slot s (1..3) goes to `rx_oct_o[(s-1)*8 +: 8]`. Capture happens regardless of `en_i`.
- R8: `rx_vld_o[s]` pulses for exactly one cycle, in the cycle right after the last cell of slot s (s = 0..3), together with the updated data. No other slot raises a strobe, and at most one bit is ever set.
- R9: Without a further frame pulse, the counters wrap from timeslot 31 bit 0 back to timeslot 0 bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Double-rate bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fp_ni | input | 1 | Active-low frame pulse |
| rx_i | input | 1 | Serial receive line |
| en_i | input | 4 | Per-slot transmit enables, bit s for timeslot s |
| tx_dch_i | input | 2 | Signalling bit pair for timeslot 0 |
| tx_oct_i | input | 24 | Octets for timeslots 1..3, slot s at bits (s-1)*8 +: 8 |
| dout_o | output | 1 | Serial transmit data |
| doe_o | output | 1 | Output enable for the transmit pad |
| rx_dch_o | output | 2 | Received signalling bit pair of timeslot 0 |
| rx_oct_o | output | 24 | Received octets of timeslots 1..3 |
| rx_vld_o | output | 4 | One-cycle strobe per captured slot |

## Verification
The hardest case to reach from the ports is proving that receive sampling happens at the three-quarter point rather than at either clock edge that bounds a cell. The bench drives the inverse of each bit during the first half of the cell. It switches to the true bit just before the mid-cell falling edge, and then inverts it again before the cell ends. Only a design that samples at the correct instant can assemble the expected octets. The stimulus also lets a frame run past timeslot 31 with no pulse, to show the counter wrap. It then cuts a frame short with a new pulse, to show realignment part-way through a slot.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int TDM_NSLOT = 32;
  localparam int TDM_NBIT  = 8;
  localparam int TDM_NUSED = 4;
  localparam int TDM_DBITS = 2;

  typedef enum logic [1:0] {SK_IDLE, SK_DCH, SK_OCT} slot_kind_e;

  // Which treatment a timeslot gets on transmit.
  function automatic slot_kind_e slot_kind(input int slot, input int nused);
    if (slot == 0) return SK_DCH;
    if (slot < nused) return SK_OCT;
    return SK_IDLE;
  endfunction
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int NSLOT = tdm_pkg::TDM_NSLOT,
  parameter int NBIT  = tdm_pkg::TDM_NBIT,
  localparam int SW = $clog2(NSLOT),
  localparam int BW = $clog2(NBIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fp_n,
  output logic [SW-1:0] cur_slot,
  output logic [BW-1:0] cur_bit,
  output logic          cur_ph,
  output logic [SW-1:0] nxt_slot,
  output logic [BW-1:0] nxt_bit,
  output logic          nxt_ph,
  output logic          locked,
  output logic          nxt_locked
);
  always_comb begin
    nxt_slot = cur_slot;
    nxt_bit  = cur_bit;
    nxt_ph   = ~cur_ph;
    if (cur_ph) begin
      if (cur_bit == BW'(NBIT - 1)) begin
        nxt_bit  = '0;
        nxt_slot = (cur_slot == SW'(NSLOT - 1)) ? '0 : cur_slot + 1'b1;
      end else begin
        nxt_bit = cur_bit + 1'b1;
      end
    end
    if (!fp_n) begin
      nxt_slot = '0;
      nxt_bit  = '0;
      nxt_ph   = 1'b0;
    end
  end

  assign nxt_locked = locked | ~fp_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_slot <= '0;
      cur_bit  <= '0;
      cur_ph   <= 1'b0;
      locked   <= 1'b0;
    end else begin
      cur_slot <= nxt_slot;
      cur_bit  <= nxt_bit;
      cur_ph   <= nxt_ph;
      locked   <= nxt_locked;
    end
  end

  AST_FP_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    !fp_n |=> (cur_slot == '0 && cur_bit == '0 && !cur_ph)); // R2

  AST_PHASE_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    fp_n |=> (cur_ph != $past(cur_ph))); // R3

  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_n && cur_ph && cur_bit == BW'(NBIT - 1) && cur_slot == SW'(NSLOT - 1))
      |=> (cur_slot == '0 && cur_bit == '0)); // R9
endmodule

// File: rtl/tdm_tx_drive.sv
module tdm_tx_drive #(
  parameter int NSLOT = tdm_pkg::TDM_NSLOT,
  parameter int NBIT  = tdm_pkg::TDM_NBIT,
  parameter int NUSED = tdm_pkg::TDM_NUSED,
  parameter int DBITS = tdm_pkg::TDM_DBITS,
  localparam int SW = $clog2(NSLOT),
  localparam int BW = $clog2(NBIT),
  localparam int OW = (NUSED - 1) * NBIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SW-1:0]    nxt_slot,
  input  logic [BW-1:0]    nxt_bit,
  input  logic             nxt_ph,
  input  logic             nxt_locked,
  input  logic [NUSED-1:0] en,
  input  logic [DBITS-1:0] tx_dch,
  input  logic [OW-1:0]    tx_oct,
  output logic             dout,
  output logic             doe
);
  import tdm_pkg::*;

  // Returns {output enable, data} for one bit cell.
  function automatic logic [1:0] cell_drive(
    input logic [SW-1:0]    slot,
    input logic [BW-1:0]    bitn,
    input logic             lock,
    input logic [NUSED-1:0] en_v,
    input logic [DBITS-1:0] dch,
    input logic [OW-1:0]    oct
  );
    int pos;
    int s;
    pos = NBIT - 1 - int'(bitn);
    s   = int'(slot);
    cell_drive = 2'b00;
    if (lock) begin
      case (slot_kind(s, NUSED))
        SK_DCH:  if (pos < DBITS) cell_drive = {1'b1, en_v[0] & dch[pos]};
        SK_OCT:  cell_drive = {en_v[s], en_v[s] & oct[(s - 1) * NBIT + pos]};
        default: cell_drive = 2'b00;
      endcase
    end
  endfunction

  logic [1:0] cell_val;
  assign cell_val = cell_drive(nxt_slot, nxt_bit, nxt_locked, en, tx_dch, tx_oct);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doe  <= 1'b0;
      dout <= 1'b0;
    end else if (!nxt_ph) begin
      {doe, dout} <= cell_val;
    end
  end
endmodule

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture #(
  parameter int NSLOT = tdm_pkg::TDM_NSLOT,
  parameter int NBIT  = tdm_pkg::TDM_NBIT,
  parameter int NUSED = tdm_pkg::TDM_NUSED,
  parameter int DBITS = tdm_pkg::TDM_DBITS,
  localparam int SW = $clog2(NSLOT),
  localparam int BW = $clog2(NBIT),
  localparam int OW = (NUSED - 1) * NBIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx,
  input  logic [SW-1:0]    cur_slot,
  input  logic [BW-1:0]    cur_bit,
  input  logic             cur_ph,
  input  logic             locked,
  output logic [DBITS-1:0] rx_dch,
  output logic [OW-1:0]    rx_oct,
  output logic [NUSED-1:0] vld
);
  logic            half;
  logic [NBIT-1:0] sh;
  logic [NBIT-1:0] new_oct;
  logic            take;
  logic            oct_done;
  logic [NUSED-1:0] hit;

  // The falling edge in the second cycle of a cell is the 3/4 point.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) half <= 1'b0;
    else        half <= rx;
  end

  assign take     = locked && cur_ph;
  assign new_oct  = {sh[NBIT-2:0], half};
  assign oct_done = take && (cur_bit == BW'(NBIT - 1));

  for (genvar s = 0; s < NUSED; s++) begin : g_hit
    assign hit[s] = oct_done && (cur_slot == SW'(s));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      vld    <= '0;
      rx_dch <= '0;
      rx_oct <= '0;
    end else begin
      vld <= hit;
      if (take) sh <= new_oct;
      if (hit[0]) rx_dch <= new_oct[DBITS-1:0];
      for (int s = 1; s < NUSED; s++)
        if (hit[s]) rx_oct[(s - 1) * NBIT +: NBIT] <= new_oct;
    end
  end

  AST_VLD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vld)); // R8

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|vld) |=> !(|vld)); // R8
endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port #(
  parameter int NSLOT = tdm_pkg::TDM_NSLOT,
  parameter int NBIT  = tdm_pkg::TDM_NBIT,
  parameter int NUSED = tdm_pkg::TDM_NUSED,
  parameter int DBITS = tdm_pkg::TDM_DBITS,
  localparam int SW = $clog2(NSLOT),
  localparam int BW = $clog2(NBIT),
  localparam int OW = (NUSED - 1) * NBIT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_ni,
  input  logic             rx_i,
  input  logic [NUSED-1:0] en_i,
  input  logic [DBITS-1:0] tx_dch_i,
  input  logic [OW-1:0]    tx_oct_i,
  output logic             dout_o,
  output logic             doe_o,
  output logic [DBITS-1:0] rx_dch_o,
  output logic [OW-1:0]    rx_oct_o,
  output logic [NUSED-1:0] rx_vld_o
);
  logic [SW-1:0] cur_slot, nxt_slot;
  logic [BW-1:0] cur_bit, nxt_bit;
  logic          cur_ph, nxt_ph;
  logic          locked, nxt_locked;

  tdm_frame_timer #(.NSLOT(NSLOT), .NBIT(NBIT)) u_timer (
    .clk(clk_i), .rst_n(rst_ni), .fp_n(fp_ni),
    .cur_slot(cur_slot), .cur_bit(cur_bit), .cur_ph(cur_ph),
    .nxt_slot(nxt_slot), .nxt_bit(nxt_bit), .nxt_ph(nxt_ph),
    .locked(locked), .nxt_locked(nxt_locked)
  );

  tdm_tx_drive #(.NSLOT(NSLOT), .NBIT(NBIT), .NUSED(NUSED), .DBITS(DBITS)) u_tx (
    .clk(clk_i), .rst_n(rst_ni),
    .nxt_slot(nxt_slot), .nxt_bit(nxt_bit), .nxt_ph(nxt_ph), .nxt_locked(nxt_locked),
    .en(en_i), .tx_dch(tx_dch_i), .tx_oct(tx_oct_i),
    .dout(dout_o), .doe(doe_o)
  );

  tdm_rx_capture #(.NSLOT(NSLOT), .NBIT(NBIT), .NUSED(NUSED), .DBITS(DBITS)) u_rx (
    .clk(clk_i), .rst_n(rst_ni), .rx(rx_i),
    .cur_slot(cur_slot), .cur_bit(cur_bit), .cur_ph(cur_ph), .locked(locked),
    .rx_dch(rx_dch_o), .rx_oct(rx_oct_o), .vld(rx_vld_o)
  );

  AST_PRELOCK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked |-> (!doe_o && !dout_o)); // R6

  AST_SPARE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && cur_slot >= SW'(NUSED)) |-> (!doe_o && !dout_o)); // R6

  AST_DCH_UPPER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && cur_slot == '0 && cur_bit < BW'(NBIT - DBITS)) |-> !doe_o); // R4

  AST_CELL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && cur_ph) |-> ($stable(doe_o) && $stable(dout_o))); // R3
endmodule

// File: tb/tdm_slot_port_test.sv
module tdm_slot_port_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fp_n = 1'b1;
  logic        rx = 1'b0;
  logic [3:0]  en = '0;
  logic [1:0]  tx_dch = '0;
  logic [23:0] tx_oct = '0;
  logic        dout, doe;
  logic [1:0]  rx_dch;
  logic [23:0] rx_oct;
  logic [3:0]  rx_vld;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [1:0] exp_tx_q[$];
  string      tag_q[$];
  logic [9:0] exp_rx_q[$];
  event       chk_ev;

  always #(CLK_P / 2) clk = ~clk;

  tdm_slot_port uut (
    .clk_i(clk), .rst_ni(rst_n), .fp_ni(fp_n), .rx_i(rx),
    .en_i(en), .tx_dch_i(tx_dch), .tx_oct_i(tx_oct),
    .dout_o(dout), .doe_o(doe), .rx_dch_o(rx_dch), .rx_oct_o(rx_oct), .rx_vld_o(rx_vld)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected {enable, data} of a cell, from the slot rules.
  function automatic logic [1:0] want_tx(input int s, input int b, input logic [3:0] e,
                                         input logic [1:0] d, input logic [23:0] o);
    int p;
    p = 7 - b;
    if (s >= 4) return 2'b00;
    if (s == 0) begin
      if (p > 1) return 2'b00;
      return e[0] ? {1'b1, d[p]} : 2'b10;
    end
    if (!e[s]) return 2'b00;
    return {1'b1, o[8 * (s - 1) + p]};
  endfunction

  function automatic string kind_tag(input int s);
    if (s == 0) return "R4";
    if (s < 4)  return "R5";
    return "R6";
  endfunction

  // Driver: optional frame pulse, then nslots timeslots of cells.
  task automatic run_slots(input bit pulse, input int nslots, input logic [3:0] e,
                           input logic [1:0] d, input logic [23:0] o, input string tag);
    en = e; tx_dch = d; tx_oct = o;
    if (pulse) begin
      @(posedge clk); #2 fp_n = 1'b0;
    end
    for (int s = 0; s < nslots; s++) begin
      logic [7:0] rb;
      rb = 8'($urandom);
      for (int b = 0; b < 8; b++) begin
        @(posedge clk); #2;
        fp_n = 1'b1;
        rx = ~rb[7 - b];
        exp_tx_q.push_back(want_tx(s, b, e, d, o));
        tag_q.push_back({kind_tag(s), " R3 ", tag});
        @(posedge clk); #2 rx = rb[7 - b];
        #1 -> chk_ev;
        #4 rx = ~rb[7 - b];
      end
      if (s < 4) exp_rx_q.push_back({2'(s), rb});
    end
  endtask

  // Monitor for the transmit line, sampled in the second cycle of each cell.
  initial begin
    forever begin
      @(chk_ev);
      if (exp_tx_q.size() == 0) begin
        check(1'b0, "R3 unexpected cell", 32'(0), 32'(0));
      end else begin
        logic [1:0] w;
        string t;
        w = exp_tx_q.pop_front();
        t = tag_q.pop_front();
        check({doe, dout} == w, t, 32'({doe, dout}), 32'(w));
      end
    end
  end

  // Monitor for captured octets and their strobes.
  initial begin
    forever begin
      @(posedge clk); #3;
      if (rst_n && rx_vld != 4'b0) begin
        if (exp_rx_q.size() == 0) begin
          check(1'b0, "R8 strobe with nothing expected", 32'(rx_vld), 32'(0));
        end else begin
          logic [9:0] it;
          int sl;
          it = exp_rx_q.pop_front();
          sl = int'(it[9:8]);
          check(rx_vld == 4'(1 << sl), "R8 strobe slot", 32'(rx_vld), 32'(1 << sl));
          if (sl == 0)
            check(rx_dch == it[1:0], "R7 dch pair", 32'(rx_dch), 32'(it[1:0]));
          else
            check(rx_oct[8 * (sl - 1) +: 8] == it[7:0], "R7 octet", 32'(rx_oct[8 * (sl - 1) +: 8]), 32'(it[7:0]));
        end
      end
    end
  end

  initial begin
    #(CLK_P * 3 + 2);
    check({doe, dout, rx_vld, rx_dch} == 0 && rx_oct == 0, "R1 reset outputs",
          32'({doe, dout, rx_vld, rx_dch}), 32'(0));
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      repeat (7) @(posedge clk);
      #3 check(!doe && !dout && rx_vld == 0, "R1 R6 before first pulse", 32'({doe, dout, rx_vld}), 32'(0));
    end
    run_slots(1'b1, 32, 4'b1111, 2'b10, 24'hA5_3C_81, "full frame");
    run_slots(1'b0, 32, 4'b0101, 2'b01, 24'h7E_00_C3, "R9 wrap");
    run_slots(1'b1, 6, 4'b0000, 2'b11, 24'hFF_FF_FF, "R7 disabled");
    run_slots(1'b1, 5, 4'b1010, 2'b11, 24'h12_96_E1, "R2 realign");
    repeat (20) @(posedge clk);
    #3 check(exp_rx_q.size() == 0, "R8 missing strobes", 32'(exp_rx_q.size()), 32'(0));
    check(exp_tx_q.size() == 0, "R3 unchecked cells", 32'(exp_tx_q.size()), 32'(0));
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule